// File: doc/BRIEF.md
# Address Window Base/Mask Decoder

This block holds the programmed address windows of a host-side bridge and tells, for any 64-bit address presented to it, which of those windows claims the address and where inside the window it falls. Six windows exist: a configuration-space window, a message window, three outbound windows with full 64-bit masks, and a register window. Each window has a 64-bit base built from two 32-bit words and a mask. The configuration, message and register windows have one 32-bit mask word, and the upper 32 mask bits of those windows are implied ones.

Software programs the windows through a word-addressed control-register bus. Every storage word reads back exactly what was last written. The block also reports the size of the configuration window, capped at a ceiling, and the size of the register window. The bank base is a parameter, so a chip with two bridges instantiates the block twice: once at word address 0x100 and once at 0x120. The decode path is purely combinational, so the lookup result is available in the cycle in which the address is presented.

Top module: `addr_window_decoder`

## Requirements
- R1: After a synchronous active-low reset, every storage word is zero. As a result, no window is enabled, `hit_any` is 0, and every in-bank read returns 0.
- R2: The words sit at these offsets from `BANK_BASE`:
  - 0/1/2: config base upper half, base lower half, mask.
  - 3/4/5: the same three words for the message window.
  - 6+4k to 9+4k, for outbound window k=0..2: base upper, base lower, mask upper, mask lower.
  - 18/19/20: the same three words for the register window.
  - 21: the spare word.
  - 22: the control word.
- R3: A write to an in-bank offset replaces only that 32-bit word, so writing one half of a base keeps the other half. A read puts the addressed word on `bus_rdata` at the clock edge that samples the request, and the value holds until the next read.
- R4: An access outside the 23-word bank changes no storage. A read of such an address returns 0.
- R5: Bit 0 of a window's mask word enables that window. For outbound windows this is the lower mask word. A disabled window never hits, and `cfg_en` shows the configuration enable.
- R6: An enabled window hits when (addr AND M) equals (base AND M). M is the 64-bit mask with bit 0 forced to 0, and the upper 32 bits of M are all ones for the windows that have a single mask word.
- R7: `hit_vec` has bit i set for each window that hits. The window indices are config 0, message 1, outbound 2 to 4, register 5. When several windows hit, `hit_idx` is the lowest hitting index.
- R8: `hit_offset` is the address minus the winning window's base, modulo 2^64. When nothing hits, `hit_any`, `hit_idx` and `hit_offset` are all 0.
- R9: The configuration window size is 2^32 minus (mask AND 0xFFFFFFFE), on 33 bits. When this value exceeds `SIZE_CAP` (default 0x1000_0000), `cfg_size` is `SIZE_CAP`; otherwise it is the value itself.
- R10: When the register-window mask word equals 0x00007001, `rw_size` is 4096. Otherwise `rw_size` follows the R9 rule with no cap applied.
- R11: The spare and control words are plain storage. They read back what was written and have no effect on any decode output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Control bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW (10) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| look_addr | input | 64 | Address to decode |
| hit_vec | output | 6 | Per-window hit flags |
| hit_any | output | 1 | Some window hits |
| hit_idx | output | 3 | Index of the winning window |
| hit_offset | output | 64 | Address minus the winner's base |
| cfg_en | output | 1 | Configuration window enable |
| cfg_size | output | 33 | Capped configuration window size |
| rw_size | output | 33 | Register window size |

## Verification
The decoder is tried with the following address patterns:
- An address inside two overlapping windows, which separates correct priority from a last-match-wins encoder.
- An address that differs from a base only in bit 0, which shows that the enable bit is kept out of the compare.
- Addresses just past a window's top and with a wrong upper word, which show that the mask bounds and the implied upper ones are applied.

The enable bits are then toggled on two outbound windows that share a base. This tells a winner chosen by enable apart from one chosen by address alone.

Size patterns cover the following cases:
- A mask exactly at the cap.
- Masks above and below the cap.
- The fixed 0x7001 code.
- A bare enable bit on the register window, which must not be capped.

Writes and reads outside the bank, and writes to the spare and control words, are each followed by read-back of neighbouring words and by a repeated decode.

// File: rtl/awd_pkg.sv
// Package: shared widths, word offsets, window indices and the mask-to-size
// rule for the address window decoder. Assumes a 32-bit control word and
// 64-bit addresses built from two words.
package awd_pkg;

    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 2 * WORD_W;
    localparam int NUM_OB  = 3;
    localparam int WIN_N   = NUM_OB + 3;
    localparam int IDX_W   = $clog2(WIN_N);
    localparam int SIZE_W  = WORD_W + 1;

    // word offsets inside the bank (decoded by software, so they are fixed)
    localparam int OFF_CFG_BH   = 0;
    localparam int OFF_CFG_BL   = 1;
    localparam int OFF_CFG_MSK  = 2;
    localparam int OFF_MSG_BH   = 3;
    localparam int OFF_MSG_BL   = 4;
    localparam int OFF_MSG_MSK  = 5;
    localparam int OFF_OB_FIRST = 6;
    localparam int OB_STRIDE    = 4;
    localparam int OFF_RW_BH    = OFF_OB_FIRST + OB_STRIDE * NUM_OB;
    localparam int OFF_RW_BL    = OFF_RW_BH + 1;
    localparam int OFF_RW_MSK   = OFF_RW_BH + 2;
    localparam int OFF_SPARE    = OFF_RW_BH + 3;
    localparam int OFF_CTL      = OFF_RW_BH + 4;
    localparam int REG_N        = OFF_CTL + 1;
    localparam int WIN_REG_N    = OFF_SPARE;
    localparam int SLOT_W       = $clog2(REG_N);

    // window indices, lowest wins
    localparam int WIN_CFG = 0;
    localparam int WIN_MSG = 1;
    localparam int WIN_OB0 = 2;
    localparam int WIN_RW  = WIN_N - 1;

    localparam logic [WORD_W-1:0] RW_FIXED_MASK = 32'h0000_7001;
    localparam logic [SIZE_W-1:0] RW_FIXED_SIZE = SIZE_W'(4096);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
    } win_t;

    // size = 2^WORD_W minus the mask with its enable bit cleared
    function automatic logic [SIZE_W-1:0] mask_to_size(input logic [WORD_W-1:0] m);
        logic [SIZE_W-1:0] full;
        full = {1'b1, {WORD_W{1'b0}}};
        return full - {1'b0, m[WORD_W-1:1], 1'b0};
    endfunction

endpackage

// File: rtl/awd_regbank.sv
// Module: storage words of the window bank plus the control-bus decode.
// Assumes BUS_AW >= SLOT_W and that BANK_BASE + REG_N fits in BUS_AW bits.
// Reads are registered; writes land at the sampling edge.
module awd_regbank
    import awd_pkg::*;
#(
    parameter int BUS_AW    = 10,
    parameter int BANK_BASE = 256
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bus_sel,
    input  logic                                 bus_wr,
    input  logic [BUS_AW-1:0]                    bus_addr,
    input  logic [WORD_W-1:0]                    bus_wdata,
    output logic [WORD_W-1:0]                    bus_rdata,
    output logic [WIN_REG_N-1:0][WORD_W-1:0]     regs_o
);

    localparam logic [BUS_AW-1:0] BASE_A = BUS_AW'(BANK_BASE);
    localparam logic [BUS_AW-1:0] SPAN_A = BUS_AW'(REG_N);

    logic [BUS_AW-1:0]              rel;
    logic                           in_bank;
    logic [SLOT_W-1:0]              slot;
    logic                           wr_hit;
    logic                           rd_req;
    logic [WORD_W-1:0]              rd_word;
    logic [REG_N-1:0][WORD_W-1:0]   store;

    // address decode: bank membership and word slot
    always_comb begin
        rel     = bus_addr - BASE_A;
        in_bank = (bus_addr >= BASE_A) && (rel < SPAN_A);
        slot    = rel[SLOT_W-1:0];
        wr_hit  = bus_sel && bus_wr && in_bank;
        rd_req  = bus_sel && !bus_wr;
    end

    // storage words: whole-word replace on an in-bank write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= '0;
        end else if (wr_hit) begin
            store[slot] <= bus_wdata;
        end
    end

    // read mux: addressed word, or zero outside the bank
    always_comb begin
        rd_word = in_bank ? store[slot] : '0;
    end

    // read data register: loads on a read, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_req) begin
            bus_rdata <= rd_word;
        end
    end

    // window words exported to the decoder
    always_comb begin
        regs_o = store[WIN_REG_N-1:0];
    end

    // R3: an in-bank write is visible in the addressed word one edge later
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (store[$past(slot)] == $past(bus_wdata)));

    // R4: reads outside the bank return zero
    a_r4_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !in_bank) |=> (bus_rdata == '0));

    // R4: accesses outside the bank leave storage untouched
    a_r4_outside_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !in_bank) |=> $stable(store));

endmodule

// File: rtl/awd_win_match.sv
// Module: compare of one address against one window. Assumes the window's
// mask word carries the enable in bit 0 and that the bit takes no part in
// the compare. The offset is computed for every window; the caller picks one.
module awd_win_match
    import awd_pkg::*;
(
    input  logic [ADDR_W-1:0] look_addr,
    input  win_t              win,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);

    logic [ADDR_W-1:0] cmp_m;

    // masked compare with the enable bit removed from the mask
    always_comb begin
        cmp_m  = {win.mask[ADDR_W-1:1], 1'b0};
        hit    = win.mask[0] && ((look_addr & cmp_m) == (win.base & cmp_m));
        offset = look_addr - win.base;
    end

endmodule

// File: rtl/awd_prio.sv
// Module: fixed-priority pick among the window hits, lowest index first.
// Produces the index and a one-hot grant used to steer the offset.
module awd_prio
    import awd_pkg::*;
(
    input  logic [WIN_N-1:0] hits,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [WIN_N-1:0] grant
);

    // scan from the top so that the lowest hitting window is kept last
    always_comb begin
        any   = |hits;
        idx   = '0;
        grant = '0;
        for (int w = WIN_N - 1; w >= 0; w--) begin
            if (hits[w]) begin
                idx      = IDX_W'(w);
                grant    = '0;
                grant[w] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/awd_size_calc.sv
// Module: window size derivation. The configuration size is capped at
// SIZE_CAP; the register window honours one fixed mask code. Assumes
// SIZE_CAP fits in SIZE_W bits. The clock is used by assertions only.
module awd_size_calc
    import awd_pkg::*;
#(
    parameter longint unsigned SIZE_CAP = 64'h1000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cfg_mask,
    input  logic [WORD_W-1:0] rw_mask,
    output logic [SIZE_W-1:0] cfg_size,
    output logic [SIZE_W-1:0] rw_size
);

    localparam logic [SIZE_W-1:0] CAP = SIZE_W'(SIZE_CAP);

    logic [SIZE_W-1:0] cfg_raw;

    // configuration size with ceiling; register size with fixed code
    always_comb begin
        cfg_raw  = mask_to_size(cfg_mask);
        cfg_size = (cfg_raw > CAP) ? CAP : cfg_raw;
        rw_size  = (rw_mask == RW_FIXED_MASK) ? RW_FIXED_SIZE : mask_to_size(rw_mask);
    end

    // R9: the reported configuration size never exceeds the ceiling
    a_r9_cap_held: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_size <= CAP);

    // R9: a size derived from a cleared-bit-0 mask is never zero
    a_r9_size_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_size != '0);

    // R10: a register window size is always even
    a_r10_size_even: assert property (@(posedge clk) disable iff (!rst_n)
        rw_size[0] == 1'b0);

endmodule

// File: rtl/addr_window_decoder.sv
// Module: top of the address window decoder. Holds the window bank, builds
// the six base/mask pairs, matches the lookup address against each in
// parallel and picks the lowest-indexed hit. Decode is combinational;
// only the bank and the read data are registered.
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int              BUS_AW    = 10,
    parameter int              BANK_BASE = 256,
    parameter longint unsigned SIZE_CAP  = 64'h1000_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [63:0]          look_addr,
    output logic [5:0]           hit_vec,
    output logic                 hit_any,
    output logic [2:0]           hit_idx,
    output logic [63:0]          hit_offset,
    output logic                 cfg_en,
    output logic [32:0]          cfg_size,
    output logic [32:0]          rw_size
);

    localparam logic [WORD_W-1:0] ONES = {WORD_W{1'b1}};

    logic [WIN_REG_N-1:0][WORD_W-1:0] regs;
    win_t                             wins [WIN_N];
    logic [ADDR_W-1:0]                offs [WIN_N];
    logic [WIN_N-1:0]                 grant;

    awd_regbank #(
        .BUS_AW    (BUS_AW),
        .BANK_BASE (BANK_BASE)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .regs_o    (regs)
    );

    // window assembly: base halves joined, single mask words padded with ones
    always_comb begin
        wins[WIN_CFG] = '{base: {regs[OFF_CFG_BH], regs[OFF_CFG_BL]},
                          mask: {ONES, regs[OFF_CFG_MSK]}};
        wins[WIN_MSG] = '{base: {regs[OFF_MSG_BH], regs[OFF_MSG_BL]},
                          mask: {ONES, regs[OFF_MSG_MSK]}};
        for (int k = 0; k < NUM_OB; k++) begin
            wins[WIN_OB0 + k] = '{
                base: {regs[OFF_OB_FIRST + OB_STRIDE * k],
                       regs[OFF_OB_FIRST + OB_STRIDE * k + 1]},
                mask: {regs[OFF_OB_FIRST + OB_STRIDE * k + 2],
                       regs[OFF_OB_FIRST + OB_STRIDE * k + 3]}};
        end
        wins[WIN_RW]  = '{base: {regs[OFF_RW_BH], regs[OFF_RW_BL]},
                          mask: {ONES, regs[OFF_RW_MSK]}};
    end

    // one compare slice per window
    for (genvar w = 0; w < WIN_N; w++) begin : g_match
        awd_win_match u_match (
            .look_addr (look_addr),
            .win       (wins[w]),
            .hit       (hit_vec[w]),
            .offset    (offs[w])
        );
    end

    awd_prio u_prio (
        .hits  (hit_vec),
        .any   (hit_any),
        .idx   (hit_idx),
        .grant (grant)
    );

    // offset steering by the one-hot grant
    always_comb begin
        hit_offset = '0;
        for (int w = 0; w < WIN_N; w++) begin
            if (grant[w]) begin
                hit_offset = offs[w];
            end
        end
    end

    // configuration enable straight from its mask word
    always_comb begin
        cfg_en = regs[OFF_CFG_MSK][0];
    end

    awd_size_calc #(
        .SIZE_CAP (SIZE_CAP)
    ) u_size (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_mask (regs[OFF_CFG_MSK]),
        .rw_mask  (regs[OFF_RW_MSK]),
        .cfg_size (cfg_size),
        .rw_size  (rw_size)
    );

    // R1: the first cycle after reset release shows no hit
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !hit_any);

    // R7: the reported winner is one of the hitting windows
    a_r7_winner_hits: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> hit_vec[hit_idx]);

    // R7: no lower-indexed window hits than the winner
    a_r7_no_lower_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> ((hit_vec & ((WIN_N'(1) << hit_idx) - WIN_N'(1))) == '0));

    // R8: with no hit, index and offset rest at zero
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_any |-> (hit_idx == '0 && hit_offset == '0));

    // R5: a disabled configuration window never hits
    a_r5_cfg_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !hit_vec[WIN_CFG]);

endmodule

// File: tb/sim_addr_window_decoder.sv
module sim_addr_window_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] look_addr = '0;
    logic [5:0]  hit_vec;
    logic        hit_any;
    logic [2:0]  hit_idx;
    logic [63:0] hit_offset;
    logic        cfg_en;
    logic [32:0] cfg_size;
    logic [32:0] rw_size;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_q = 1'b0;

    always #4 clk = ~clk;

    addr_window_decoder u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .look_addr  (look_addr),
        .hit_vec    (hit_vec),
        .hit_any    (hit_any),
        .hit_idx    (hit_idx),
        .hit_offset (hit_offset),
        .cfg_en     (cfg_en),
        .cfg_size   (cfg_size),
        .rw_size    (rw_size)
    );

    // bench-side marker of a read sampled at this edge
    always @(posedge clk) rd_q <= bus_sel && !bus_wr;

    // monitor: pop the expected word and compare with the registered read data
    always @(negedge clk) begin
        logic [31:0] e;
        string       t;
        if (rd_q) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R3 unexpected read actual=%h expected=none", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic cmp(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // driver: push the expected word, then issue the read
    task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic look(input logic [63:0] a, input logic [5:0] ev, input logic [2:0] ei,
                        input logic [63:0] eo, input string tag);
        look_addr = a;
        #1;
        cmp({58'b0, hit_vec}, {58'b0, ev}, {tag, " hit_vec"});
        cmp({63'b0, hit_any}, {63'b0, |ev}, {tag, " hit_any"});
        cmp({61'b0, hit_idx}, {61'b0, ei}, {tag, " hit_idx"});
        cmp(hit_offset, eo, {tag, " hit_offset"});
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        rd(10'h100, 32'h0, "R1 cfg base hi");
        rd(10'h109, 32'h0, "R1 ob1 mask lo");
        rd(10'h116, 32'h0, "R1 control word");
        look(64'h0, 6'b0, 3'd0, 64'h0, "R1 no window");
        cmp({63'b0, cfg_en}, 64'h0, "R1 cfg_en");
        cmp({31'b0, cfg_size}, 64'h1000_0000, "R9 zero mask capped");
        cmp({31'b0, rw_size}, 64'h1_0000_0000, "R10 zero mask uncapped");

        // R2/R3: base halves
        wr(10'h100, 32'h0000_000C);
        wr(10'h101, 32'h1000_0000);
        rd(10'h100, 32'h0000_000C, "R3 cfg base hi");
        rd(10'h101, 32'h1000_0000, "R3 cfg base lo");
        wr(10'h100, 32'h0000_000D);
        rd(10'h101, 32'h1000_0000, "R3 low half kept");
        rd(10'h100, 32'h0000_000D, "R3 high half replaced");
        wr(10'h102, 32'hF000_0001);
        cmp({63'b0, cfg_en}, 64'h1, "R5 cfg_en set");
        cmp({31'b0, cfg_size}, 64'h1000_0000, "R9 size at cap");

        // message window overlapping the config window
        wr(10'h103, 32'h0000_000D);
        wr(10'h104, 32'h1800_0000);
        wr(10'h105, 32'hFF00_0001);
        rd(10'h105, 32'hFF00_0001, "R2 msg mask offset");
        look(64'h0000_000D_1800_0010, 6'b000011, 3'd0, 64'h0800_0010, "R7 overlap cfg wins");
        look(64'h0000_000D_1000_0001, 6'b000001, 3'd0, 64'h1, "R6 bit0 ignored");
        look(64'h0000_000D_2000_0000, 6'b0, 3'd0, 64'h0, "R8 miss above cfg");
        look(64'h0000_000C_1000_0000, 6'b0, 3'd0, 64'h0, "R6 upper word checked");

        // outbound windows 1 and 2 sharing a base
        wr(10'h106, 32'h1); wr(10'h107, 32'h0);
        wr(10'h108, 32'hFFFF_FFFF); wr(10'h109, 32'h8000_0001);
        wr(10'h10A, 32'h1); wr(10'h10B, 32'h0);
        wr(10'h10C, 32'hFFFF_FFFF); wr(10'h10D, 32'h8000_0000);
        look(64'h1_7000_0004, 6'b000100, 3'd2, 64'h7000_0004, "R5 disabled ob2 silent");
        wr(10'h10D, 32'h8000_0001);
        look(64'h1_7000_0004, 6'b001100, 3'd2, 64'h7000_0004, "R7 ob1 over ob2");
        wr(10'h109, 32'h8000_0000);
        look(64'h1_7000_0004, 6'b001000, 3'd3, 64'h7000_0004, "R5 ob1 disabled");
        look(64'h1_8000_0000, 6'b0, 3'd0, 64'h0, "R6 full mask bound");

        // outbound window 3
        wr(10'h10E, 32'h2); wr(10'h10F, 32'h0);
        wr(10'h110, 32'hFFFF_FFFF); wr(10'h111, 32'hFFFF_0001);
        rd(10'h110, 32'hFFFF_FFFF, "R2 ob3 mask hi");
        rd(10'h111, 32'hFFFF_0001, "R2 ob3 mask lo");
        look(64'h2_0000_FFFF, 6'b010000, 3'd4, 64'hFFFF, "R6 ob3 top byte");
        look(64'h2_0001_0000, 6'b0, 3'd0, 64'h0, "R8 just past ob3");

        // register window and its size rule
        wr(10'h112, 32'hE); wr(10'h113, 32'h0);
        wr(10'h114, 32'h0000_7001);
        cmp({31'b0, rw_size}, 64'h1000, "R10 fixed code");
        wr(10'h114, 32'h0000_0001);
        cmp({31'b0, rw_size}, 64'h1_0000_0000, "R10 no cap");
        wr(10'h114, 32'hFFFF_F001);
        cmp({31'b0, rw_size}, 64'h1000, "R10 two's complement");
        look(64'hE_0000_0ABC, 6'b100000, 3'd5, 64'hABC, "R7 register window index");

        // R9: cap and small sizes
        wr(10'h102, 32'hE000_0001);
        cmp({31'b0, cfg_size}, 64'h1000_0000, "R9 clamped");
        wr(10'h102, 32'hFFFF_0001);
        cmp({31'b0, cfg_size}, 64'h1_0000, "R9 below cap");
        look(64'hD_1000_0010, 6'b000001, 3'd0, 64'h10, "R6 small cfg hit");
        wr(10'h102, 32'hFFFF_0000);
        cmp({63'b0, cfg_en}, 64'h0, "R5 cfg_en cleared");
        cmp({31'b0, cfg_size}, 64'h1_0000, "R9 enable not in size");
        look(64'hD_1000_0010, 6'b0, 3'd0, 64'h0, "R5 cfg off");

        // R4: outside the bank
        wr(10'h117, 32'hDEAD_BEEF);
        wr(10'h0FF, 32'h0000_1234);
        rd(10'h117, 32'h0, "R4 above bank reads zero");
        rd(10'h0FF, 32'h0, "R4 below bank reads zero");
        rd(10'h116, 32'h0, "R4 top word untouched");
        rd(10'h100, 32'h0000_000D, "R4 bottom word untouched");

        // R11: spare and control words
        wr(10'h115, 32'hA5A5_A5A5);
        wr(10'h116, 32'h5A5A_0001);
        rd(10'h115, 32'hA5A5_A5A5, "R11 spare readback");
        rd(10'h116, 32'h5A5A_0001, "R11 control readback");
        look(64'hE_0000_0ABC, 6'b100000, 3'd5, 64'hABC, "R11 no decode effect");
        look(64'h2_0000_FFFF, 6'b010000, 3'd4, 64'hFFFF, "R11 ob3 unchanged");

        repeat (3) @(negedge clk);
        cmp(64'(exp_q.size()), 64'h0, "R3 scoreboard drained");
        summary();
        $finish;
    end

endmodule